// File: doc/BRIEF.md
# ADC Controller Register Bank

This block is the software-visible register file of a four-slot analog-to-digital conversion controller. A host reaches it over a plain 32-bit word bus with an address, a write enable, write data and combinational read data. It stores per-slot conversion settings, a sample timer word, a global power/enable word and two interrupt enable masks. It also keeps a sticky interrupt status word and the latest 12-bit result for every slot, and it drives one interrupt line toward the host.

A separate conversion engine, not part of this block, reports each slot with a single-cycle done pulse carrying that slot's result, or with a single-cycle timeout pulse. The bank latches the result, sets the matching status flag and holds it until software writes a zero to that flag. Two slot results are packed side by side into one read word, so a driver fetches a pair of conversions with one access.

Top module: `adc_reg_bank`

## Requirements
- R1: After reset every mapped register reads zero, the status flags are clear and `irq` is low.
- R2: Slot n (0..3) has a first settings word at byte offset 0x20*n and a second at 0x20*n+0x10. The first word stores only bit 31 (slot enable), bit 30 (single conversion), bit 29 (averaging) and bits 27:24 (input select); every other bit reads zero. The second word stores all 32 bits.
- R3: The sample timer word at 0x90 stores and returns all 32 bits.
- R4: The global word at 0x130 stores only bit 0 (ADC enable), bit 1 (power down) and bit 31 (clock gate); other bits read zero.
- R5: The interrupt signal-enable word at 0xC0 and the interrupt enable word at 0xD0 each store only bits 11:8 and 19:16; other bits read zero.
- R6: A done pulse for slot n sets status bit 8+n, and a timeout pulse for slot n sets bit 16+n, in the status word at 0xE0; the flag is readable from the cycle after the pulse.
- R7: Reading the status word leaves it unchanged. A write to 0xE0 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1.
- R8: A done or timeout pulse that arrives in the same cycle as a write clearing that flag leaves the flag set.
- R9: On a done pulse for slot n the bank latches that slot's 12-bit result. The word at 0xF0 returns slot 0 in bits 11:0 and slot 1 in bits 27:16; the word at 0x100 does the same for slots 2 and 3. All other bits read zero and writes to both words have no effect.
- R10: `irq` is high exactly when some status flag is set whose bit is also set in both enable words, and it follows the registers in the same cycle.
- R11: An address that is not a multiple of 16 or not in the map reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write strobe for the current address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the current address |
| slotDone | input | 4 | Per-slot conversion-done pulses |
| slotTimeout | input | 4 | Per-slot conversion-timeout pulses |
| slotResult | input | 4*RES_W | Per-slot results, slot n in bits n*RES_W upward |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the bank with its defaults, a 9-bit byte address and 12-bit results, which covers the full map up to 0x130 plus unmapped holes and misaligned addresses on both sides of it. With 12-bit results each packed word has four padding bits above each field, so leakage of stray bits is visible. A behavioural model runs beside the design every clock, and directed sequences hit the clear-while-set collision, partial clears, writes to the read-only result words and writes near the timer at misaligned offsets.

// File: rtl/adc_reg_pkg.sv
`timescale 1ns/1ps
package adc_reg_pkg;
  localparam int SLOTS    = 4;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int PAIRS    = SLOTS / 2;
  localparam int PAIR_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int WORD_W   = 32;

  // bit positions decoded by software
  localparam int DONE_LSB = 8;
  localparam int TOUT_LSB = 16;
  localparam int HI_LSB   = 16;
  localparam int GLOB_EN    = 0;
  localparam int GLOB_PWRDN = 1;
  localparam int GLOB_CLKDN = 31;
  localparam logic [WORD_W-1:0] CFG1_KEEP = 32'hEF00_0000;

  // word indices (byte address / 16)
  localparam int IDX_TIMER = 9;
  localparam int IDX_SIGEN = 12;
  localparam int IDX_INTEN = 13;
  localparam int IDX_STAT  = 14;
  localparam int IDX_RES0  = 15;
  localparam int IDX_GLOB  = 19;

  typedef enum logic [3:0] {
    RD_NONE, RD_CFG1, RD_CFG2, RD_TIMER, RD_SIG, RD_IEN, RD_STAT, RD_RES, RD_GLOB
  } rd_sel_e;

  typedef struct packed {
    logic              cfg1Wr;
    logic              cfg2Wr;
    logic              timerWr;
    logic              sigEnWr;
    logic              intEnWr;
    logic              statWr;
    logic              globWr;
    logic [SLOT_W-1:0] slotIdx;
    logic [PAIR_W-1:0] pairIdx;
    rd_sel_e           rdSel;
  } reg_strobe_t;
endpackage

// File: rtl/adc_reg_ctrl.sv
`timescale 1ns/1ps
// Address decode: turns the bus address and write strobe into register strobes.
module adc_reg_ctrl
  import adc_reg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output reg_strobe_t       stb
);
  localparam int IDX_W = ADDR_W - 4;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  int unsigned      idxVal;

  assign aligned = (busAddr[3:0] == 4'h0);
  assign wordIdx = busAddr[ADDR_W-1:4];
  assign idxVal  = 32'(wordIdx);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (aligned) begin
      if (idxVal < 2 * SLOTS) begin
        stb.slotIdx = wordIdx[SLOT_W:1];
        if (wordIdx[0]) begin
          stb.rdSel  = RD_CFG2;
          stb.cfg2Wr = busWe;
        end else begin
          stb.rdSel  = RD_CFG1;
          stb.cfg1Wr = busWe;
        end
      end else if (idxVal >= IDX_RES0 && idxVal < IDX_RES0 + PAIRS) begin
        stb.rdSel   = RD_RES;
        stb.pairIdx = PAIR_W'(idxVal - IDX_RES0);
      end else begin
        case (idxVal)
          IDX_TIMER: begin stb.rdSel = RD_TIMER; stb.timerWr = busWe; end
          IDX_SIGEN: begin stb.rdSel = RD_SIG;   stb.sigEnWr = busWe; end
          IDX_INTEN: begin stb.rdSel = RD_IEN;   stb.intEnWr = busWe; end
          IDX_STAT:  begin stb.rdSel = RD_STAT;  stb.statWr  = busWe; end
          IDX_GLOB:  begin stb.rdSel = RD_GLOB;  stb.globWr  = busWe; end
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_reg_sticky.sv
`timescale 1ns/1ps
// Sticky flags: set by event pulses, cleared by writing zero; set wins.
module adc_reg_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clrWr,
  input  logic [W-1:0] keepMask,
  input  logic [W-1:0] setPulse,
  output logic [W-1:0] flags
);
  logic [W-1:0] keep;

  assign keep = clrWr ? keepMask : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & keep) | setPulse;
  end
endmodule

// File: rtl/adc_reg_data.sv
`timescale 1ns/1ps
// Register storage, status flags, result latches and read mux.
module adc_reg_data
  import adc_reg_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  reg_strobe_t            stb,
  input  logic [WORD_W-1:0]      wrData,
  input  logic [SLOTS-1:0]       slotDone,
  input  logic [SLOTS-1:0]       slotTimeout,
  input  logic [SLOTS*RES_W-1:0] slotResult,
  output logic [WORD_W-1:0]      rdData,
  output logic [SLOTS-1:0]       doneSt,
  output logic [SLOTS-1:0]       toutSt,
  output logic [SLOTS-1:0]       doneEn,
  output logic [SLOTS-1:0]       toutEn
);
  localparam int EN_W = 2 * SLOTS;

  logic [WORD_W-1:0] cfg1All [SLOTS];
  logic [WORD_W-1:0] cfg2All [SLOTS];
  logic [RES_W-1:0]  resAll  [SLOTS];

  logic [WORD_W-1:0] timerQ;
  logic [EN_W-1:0]   sigEnQ;
  logic [EN_W-1:0]   intEnQ;
  logic [2:0]        globQ;

  function automatic logic [WORD_W-1:0] spreadFlags(input logic [EN_W-1:0] f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DONE_LSB +: SLOTS] = f[SLOTS-1:0];
    w[TOUT_LSB +: SLOTS] = f[EN_W-1:SLOTS];
    return w;
  endfunction

  // per-slot settings and result latches
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic [WORD_W-1:0] cfg1Q;
    logic [WORD_W-1:0] cfg2Q;
    logic [RES_W-1:0]  resQ;
    logic              hitSlot;

    assign hitSlot = (stb.slotIdx == SLOT_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg1Q <= '0;
        cfg2Q <= '0;
        resQ  <= '0;
      end else begin
        if (stb.cfg1Wr && hitSlot) cfg1Q <= wrData & CFG1_KEEP;
        if (stb.cfg2Wr && hitSlot) cfg2Q <= wrData;
        if (slotDone[g])           resQ  <= slotResult[g*RES_W +: RES_W];
      end
    end

    assign cfg1All[g] = cfg1Q;
    assign cfg2All[g] = cfg2Q;
    assign resAll[g]  = resQ;
  end

  // shared words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
      sigEnQ <= '0;
      intEnQ <= '0;
      globQ  <= '0;
    end else begin
      if (stb.timerWr) timerQ <= wrData;
      if (stb.sigEnWr) sigEnQ <= {wrData[TOUT_LSB +: SLOTS], wrData[DONE_LSB +: SLOTS]};
      if (stb.intEnWr) intEnQ <= {wrData[TOUT_LSB +: SLOTS], wrData[DONE_LSB +: SLOTS]};
      if (stb.globWr)  globQ  <= {wrData[GLOB_CLKDN], wrData[GLOB_PWRDN], wrData[GLOB_EN]};
    end
  end

  // sticky status, one instance per event kind
  for (genvar k = 0; k < 2; k++) begin : gFlags
    localparam int LSB = (k == 0) ? DONE_LSB : TOUT_LSB;
    logic [SLOTS-1:0] flagQ;

    adc_reg_sticky #(.W(SLOTS)) i_sticky (
      .clk      (clk),
      .rstN     (rstN),
      .clrWr    (stb.statWr),
      .keepMask (wrData[LSB +: SLOTS]),
      .setPulse ((k == 0) ? slotDone : slotTimeout),
      .flags    (flagQ)
    );

    if (k == 0) begin : gDone
      assign doneSt = flagQ;
    end else begin : gTout
      assign toutSt = flagQ;
    end
  end

  assign doneEn = sigEnQ[SLOTS-1:0]    & intEnQ[SLOTS-1:0];
  assign toutEn = sigEnQ[EN_W-1:SLOTS] & intEnQ[EN_W-1:SLOTS];

  // read mux
  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RD_CFG1:  rdData = cfg1All[stb.slotIdx];
      RD_CFG2:  rdData = cfg2All[stb.slotIdx];
      RD_TIMER: rdData = timerQ;
      RD_SIG:   rdData = spreadFlags(sigEnQ);
      RD_IEN:   rdData = spreadFlags(intEnQ);
      RD_STAT:  rdData = spreadFlags({toutSt, doneSt});
      RD_RES: begin
        rdData[RES_W-1:0]       = resAll[{stb.pairIdx, 1'b0}];
        rdData[HI_LSB +: RES_W] = resAll[{stb.pairIdx, 1'b1}];
      end
      RD_GLOB: begin
        rdData[GLOB_EN]    = globQ[0];
        rdData[GLOB_PWRDN] = globQ[1];
        rdData[GLOB_CLKDN] = globQ[2];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_reg_bank.sv
`timescale 1ns/1ps
// Top: decode, storage and interrupt combine.
module adc_reg_bank
  import adc_reg_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int RES_W  = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWe,
  input  logic [WORD_W-1:0]      busWrData,
  output logic [WORD_W-1:0]      busRdData,
  input  logic [SLOTS-1:0]       slotDone,
  input  logic [SLOTS-1:0]       slotTimeout,
  input  logic [SLOTS*RES_W-1:0] slotResult,
  output logic                   irq
);
  reg_strobe_t      stb;
  logic [SLOTS-1:0] doneSt;
  logic [SLOTS-1:0] toutSt;
  logic [SLOTS-1:0] doneEn;
  logic [SLOTS-1:0] toutEn;

  adc_reg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  adc_reg_data #(.RES_W(RES_W)) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (busWrData),
    .slotDone    (slotDone),
    .slotTimeout (slotTimeout),
    .slotResult  (slotResult),
    .rdData      (busRdData),
    .doneSt      (doneSt),
    .toutSt      (toutSt),
    .doneEn      (doneEn),
    .toutEn      (toutEn)
  );

  assign irq = |(doneSt & doneEn) | |(toutSt & toutEn);
endmodule

// File: rtl/adc_reg_bank_chk.sv
`timescale 1ns/1ps
module adc_reg_bank_chk
  import adc_reg_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int RES_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WORD_W-1:0] busRdData,
  input logic              statWr,
  input logic [SLOTS-1:0]  slotDone,
  input logic [SLOTS-1:0]  slotTimeout,
  input logic [SLOTS-1:0]  doneSt,
  input logic [SLOTS-1:0]  toutSt,
  input logic [SLOTS-1:0]  doneEn,
  input logic [SLOTS-1:0]  toutEn,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] A_RES0 = ADDR_W'(IDX_RES0 * 16);
  localparam logic [ADDR_W-1:0] A_RES1 = ADDR_W'((IDX_RES0 + 1) * 16);
  localparam logic [WORD_W-1:0] FIELD  = (32'd1 << RES_W) - 32'd1;
  localparam logic [WORD_W-1:0] RES_MASK = FIELD | (FIELD << HI_LSB);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (doneSt == '0 && toutSt == '0 && !irq)); // R1

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (slotDone != '0) |=> ((doneSt & $past(slotDone)) == $past(slotDone))); // R8

  AST_TOUT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (slotTimeout != '0) |=> ((toutSt & $past(slotTimeout)) == $past(slotTimeout))); // R6

  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !statWr |=> (((doneSt & $past(doneSt)) == $past(doneSt)) &&
                 ((toutSt & $past(toutSt)) == $past(toutSt)))); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((doneSt | toutSt) != '0)); // R10

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((doneEn | toutEn) != '0)); // R10

  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> (busRdData == '0)); // R11

  AST_RESULT_PADDING: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_RES0 || busAddr == A_RES1) |-> ((busRdData & ~RES_MASK) == '0)); // R9
endmodule

bind adc_reg_bank adc_reg_bank_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) i_adc_reg_bank_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busRdData   (busRdData),
  .statWr      (stb.statWr),
  .slotDone    (slotDone),
  .slotTimeout (slotTimeout),
  .doneSt      (doneSt),
  .toutSt      (toutSt),
  .doneEn      (doneEn),
  .toutEn      (toutEn),
  .irq         (irq)
);

// File: tb/test_adc_reg_bank.sv
`timescale 1ns/1ps
module test_adc_reg_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  slotDone = '0;
  logic [3:0]  slotTimeout = '0;
  logic [47:0] slotResult = '0;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_reg_bank i_adc_reg_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .slotDone(slotDone),
    .slotTimeout(slotTimeout), .slotResult(slotResult), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCfg1 [4];
  logic [31:0] mCfg2 [4];
  logic [11:0] mRes  [4];
  logic [31:0] mTimer, mSig, mIen, mStat, mGlob;

  always @(posedge clk) begin
    int a;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mCfg1[i] = 0; mCfg2[i] = 0; mRes[i] = 0; end
      mTimer = 0; mSig = 0; mIen = 0; mStat = 0; mGlob = 0;
    end else begin
      a = busAddr;
      if (busWe) begin
        if (a % 16 == 0 && a < 128) begin
          if ((a / 16) % 2 == 1) mCfg2[a/32] = busWrData;
          else                   mCfg1[a/32] = busWrData & 32'hEF00_0000;
        end else begin
          case (a)
            'h090: mTimer = busWrData;
            'h0C0: mSig   = busWrData & 32'h000F_0F00;
            'h0D0: mIen   = busWrData & 32'h000F_0F00;
            'h0E0: mStat  = mStat & busWrData;
            'h130: mGlob  = busWrData & 32'h8000_0003;
            default: ;
          endcase
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (slotDone[i]) begin
          mStat[8+i] = 1'b1;
          mRes[i] = slotResult[i*12 +: 12];
        end
        if (slotTimeout[i]) mStat[16+i] = 1'b1;
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [8:0] addr);
    int a = addr;
    if (a % 16 != 0) return 32'h0;
    if (a < 128) return ((a / 16) % 2 == 1) ? mCfg2[a/32] : mCfg1[a/32];
    case (a)
      'h090: return mTimer;
      'h0C0: return mSig;
      'h0D0: return mIen;
      'h0E0: return mStat;
      'h0F0: return {4'h0, mRes[1], 4'h0, mRes[0]};
      'h100: return {4'h0, mRes[3], 4'h0, mRes[2]};
      'h130: return mGlob;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [8:0] addr);
    int a = addr;
    if (a % 16 != 0) return "R11";
    if (a < 128) return "R2";
    case (a)
      'h090: return "R3";
      'h0C0, 'h0D0: return "R5";
      'h0E0: return "R7";
      'h0F0, 'h100: return "R9";
      'h130: return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare with the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busRdData, modelRead(busAddr), tagFor(busAddr), "model read");
      check({31'b0, irq}, {31'b0, |(mStat & mSig & mIen)}, "R10", "model irq");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input logic [8:0] a, input logic we, input logic [31:0] wd,
                      input logic [3:0] dn, input logic [3:0] to, input logic [47:0] res);
    @(posedge clk); #2;
    busAddr = a; busWe = we; busWrData = wd;
    slotDone = dn; slotTimeout = to; slotResult = res;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    step(a, 1'b1, d, 4'h0, 4'h0, 48'h0);
  endtask

  task automatic rd(input logic [8:0] a);
    step(a, 1'b0, 32'h0, 4'h0, 4'h0, 48'h0);
  endtask

  task automatic expectRd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    rd(a);
    @(negedge clk);
    check(busRdData, exp, tag, $sformatf("read %h", a));
  endtask

  task automatic expectIrq(input logic exp, input string tag);
    @(negedge clk);
    check({31'b0, irq}, {31'b0, exp}, tag, "irq");
  endtask

  task automatic finishRun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  // ---------------- test sequence ----------------
  initial begin
    int addrList [16];
    addrList = '{'h000, 'h010, 'h020, 'h030, 'h040, 'h050, 'h060, 'h070,
                 'h090, 'h0C0, 'h0D0, 'h0E0, 'h0F0, 'h100, 'h130, 'h0A2};
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 15; i++) expectRd(9'(addrList[i]), 32'h0, "R1");
    expectIrq(1'b0, "R1");

    // R2: slot settings
    wr(9'h000, 32'hFFFF_FFFF); expectRd(9'h000, 32'hEF00_0000, "R2");
    wr(9'h020, 32'hA5A5_A5A5); expectRd(9'h020, 32'hA500_0000, "R2");
    wr(9'h060, 32'h10FF_FFFF); expectRd(9'h060, 32'h0000_0000, "R2");
    wr(9'h050, 32'h1234_5678); expectRd(9'h050, 32'h1234_5678, "R2");
    wr(9'h070, 32'hDEAD_BEEF); expectRd(9'h070, 32'hDEAD_BEEF, "R2");
    expectRd(9'h000, 32'hEF00_0000, "R2");

    // R3: timer
    wr(9'h090, 32'h2000_0001); expectRd(9'h090, 32'h2000_0001, "R3");

    // R4: global word
    wr(9'h130, 32'hFFFF_FFFF); expectRd(9'h130, 32'h8000_0003, "R4");
    wr(9'h130, 32'h7FFF_FFFC); expectRd(9'h130, 32'h0000_0000, "R4");
    wr(9'h130, 32'h0000_0001); expectRd(9'h130, 32'h0000_0001, "R4");

    // R5: enables
    wr(9'h0C0, 32'hFFFF_FFFF); expectRd(9'h0C0, 32'h000F_0F00, "R5");
    wr(9'h0D0, 32'h0001_0100); expectRd(9'h0D0, 32'h0001_0100, "R5");

    // R6, R9: done on slot 1 with result
    step(9'h0E0, 1'b0, 32'h0, 4'b0010, 4'h0, 48'h0000_00AB_C000);
    expectRd(9'h0E0, 32'h0000_0200, "R6");
    expectIrq(1'b0, "R10");
    expectRd(9'h0F0, 32'h0ABC_0000, "R9");

    // R7: reads and writes of one keep, writes of zero clear
    expectRd(9'h0E0, 32'h0000_0200, "R7");
    wr(9'h0E0, 32'hFFFF_FFFF); expectRd(9'h0E0, 32'h0000_0200, "R7");
    wr(9'h0E0, 32'hFFFF_FDFF); expectRd(9'h0E0, 32'h0000_0000, "R7");

    // R10: enabled done flag raises irq
    step(9'h0E0, 1'b0, 32'h0, 4'b0001, 4'h0, 48'h0000_0000_0123);
    expectRd(9'h0E0, 32'h0000_0100, "R6");
    expectIrq(1'b1, "R10");
    expectRd(9'h0F0, 32'h0ABC_0123, "R9");

    // R6: timeout on slot 3
    step(9'h0E0, 1'b0, 32'h0, 4'h0, 4'b1000, 48'h0);
    expectRd(9'h0E0, 32'h0008_0100, "R6");

    // R8: events in the same cycle as a clearing write
    step(9'h0E0, 1'b1, 32'h0, 4'b0100, 4'b0001, 48'h000F_FF00_0000);
    expectRd(9'h0E0, 32'h0001_0400, "R8");
    expectIrq(1'b1, "R10");
    expectRd(9'h100, 32'h0000_0FFF, "R9");
    wr(9'h0E0, 32'hFFFE_FFFF); expectRd(9'h0E0, 32'h0000_0400, "R7");
    expectIrq(1'b0, "R10");

    // R9: result words ignore writes
    wr(9'h0F0, 32'hFFFF_FFFF); expectRd(9'h0F0, 32'h0ABC_0123, "R9");
    wr(9'h100, 32'h0000_0000); expectRd(9'h100, 32'h0000_0FFF, "R9");

    // R11: unmapped and misaligned
    wr(9'h093, 32'hFFFF_FFFF); expectRd(9'h090, 32'h2000_0001, "R11");
    expectRd(9'h093, 32'h0, "R11");
    wr(9'h080, 32'h1111_1111); expectRd(9'h080, 32'h0, "R11");
    wr(9'h0A0, 32'h2222_2222); expectRd(9'h0A0, 32'h0, "R11");
    wr(9'h004, 32'h3333_3333); expectRd(9'h004, 32'h0, "R11");
    expectRd(9'h000, 32'hEF00_0000, "R11");

    // mixed traffic against the model (R6 R7 R8 R10)
    for (int n = 0; n < 400; n++) begin
      step(9'(addrList[$urandom_range(0, 15)]), 1'($urandom_range(0, 1)), $urandom,
           4'($urandom) & 4'($urandom) & 4'($urandom),
           4'($urandom) & 4'($urandom) & 4'($urandom),
           {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
    end
    rd(9'h0E0);
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule